// File: doc/BRIEF.md
# Local Frame Transmit Handshake Controller

This block delivers one local frame from the device to an attached host and then handles the host's one-character reply. The device may start a transfer at any time and needs no prior request from the host. After a one-cycle send request, the block reads the frame buffer one byte at a time, from index 0 up to a final index. It hands each byte to a UART transmitter over a valid/ready byte interface. The frame bytes are assumed to be prepared already: the checksum and the serializer live elsewhere.

Once the final byte has been accepted, the block watches the byte stream from the UART receiver. A positive reply, a framing error, or silence for the whole reply window ends the transfer as a success. A negative reply causes one resend after a short wait-before-continue gap. A second negative reply ends the transfer as a failure. All waits are counted in ticks of a free-running 0.25 ms timebase strobe. The defaults are 160 ticks (40 ms) for the reply window and 20 ticks (5 ms) for the gap.

Top module: `frame_tx_handshake`

## Requirements
- R1: A send request is taken only while the block is idle. `busy_o` rises on the cycle after the request and falls on the cycle in which `done_o` or `failed_o` is high. A request made while busy has no effect: no further frame is sent after the current result.
- R2: The frame is sent in index order 0, 1, … up to the latched final index. `tx_data_o` equals the buffer byte at `buf_addr_o`. While `tx_valid_o` is high and `tx_ready_i` is low, the index and the valid signal hold.
- R3: While a reply is awaited, a received byte of 0x06 (acknowledge) produces a one-cycle `done_o` on the next cycle, and no `failed_o`.
- R4: If no reply arrives, `done_o` follows the ACK_TICKS-th tick counted after the last byte was accepted (160 by default). Nothing is reported before that tick.
- R5: A framing error reported while a reply is awaited counts as an acknowledge and produces `done_o`. This holds even when it comes with a byte value.
- R6: The first received byte of 0x15 (negative acknowledge) starts a gap. No byte is offered during the gap. The frame is then resent from index 0 on the cycle after the WBC_TICKS-th tick of the gap (20 by default).
- R7: A 0x15 reply to the resent frame produces a one-cycle `failed_o` and a return to idle, with no third transmission.
- R8: Received bytes other than 0x06 and 0x15 during the reply wait have no effect. Received bytes and framing errors while idle have no effect.
- R9: `done_o` and `failed_o` are never high together. Each lasts one cycle and appears only at the end of a busy period.
- R10: After reset, `busy_o`, `done_o`, `failed_o`, `tx_valid_o` and `buf_rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe of the 0.25 ms timebase |
| send_req_i | input | 1 | One-cycle request to send a frame |
| frame_last_i | input | ADDR_W | Index of the final frame byte, latched with the request |
| buf_rd_o | output | 1 | Frame buffer read enable |
| buf_addr_o | output | ADDR_W | Frame buffer byte index |
| buf_data_i | input | 8 | Buffer byte at `buf_addr_o`, valid in the same cycle |
| tx_data_o | output | 8 | Byte offered to the UART transmitter |
| tx_valid_o | output | 1 | Byte offer valid |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| rx_data_i | input | 8 | Byte from the UART receiver |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_frm_err_i | input | 1 | Framing error strobe from the receiver |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle success pulse |
| failed_o | output | 1 | One-cycle failure pulse |

## Verification
The hardest case to reach from the ports is the failure path. It needs a complete frame, a negative reply, the full gap, the whole resent frame, and then a second negative reply, all with exact timing. The bench drives the timebase strobe itself, one tick at a time. This lets it stop one tick short of each window and confirm that nothing has happened yet, then give the final tick and check the output on the next cycle. Frames are sent with a stall on every byte, so the hold behaviour is exercised on every index and not only the first.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_GAP  = 2'd3
  } ftx_state_e;

  localparam logic [7:0] CHR_ACK = 8'h06;
  localparam logic [7:0] CHR_NAK = 8'h15;

endpackage

// File: rtl/ftx_byte_feeder.sv
module ftx_byte_feeder #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic              tx_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tx_valid_o,
  output logic              last_taken_o
);

  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              take;

  assign take         = active_i && tx_ready_i;
  assign last_taken_o = take && (idx_q == last_i);
  assign tx_valid_o   = active_i;
  assign addr_o       = idx_q;

  always_comb begin
    idx_d = idx_q;
    if (!active_i)         idx_d = '0;
    else if (last_taken_o) idx_d = '0;
    else if (take)         idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end

endmodule

// File: rtl/ftx_reply_decoder.sv
module ftx_reply_decoder
  import ftx_pkg::*;
(
  input  logic       armed_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  input  logic       rx_frm_err_i,
  output logic       accept_o,
  output logic       reject_o
);

  always_comb begin
    accept_o = 1'b0;
    reject_o = 1'b0;
    if (armed_i) begin
      if (rx_frm_err_i)                             accept_o = 1'b1;
      else if (rx_valid_i && rx_data_i == CHR_ACK)  accept_o = 1'b1;
      else if (rx_valid_i && rx_data_i == CHR_NAK)  reject_o = 1'b1;
    end
  end

endmodule

// File: rtl/ftx_tick_timer.sv
module ftx_tick_timer #(
  parameter int ACK_TICKS = 160,
  parameter int WBC_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic sel_gap_i,
  input  logic tick_i,
  output logic expired_o
);

  localparam int MAX_TICKS = (ACK_TICKS > WBC_TICKS) ? ACK_TICKS : WBC_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] final_cnt;
  logic             cnt_en;

  assign final_cnt = sel_gap_i ? CNT_W'(WBC_TICKS - 1) : CNT_W'(ACK_TICKS - 1);
  assign expired_o = run_i && tick_i && (cnt_q == final_cnt);
  assign cnt_en    = clr_i || (run_i && tick_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                cnt_d = '0;
    else if (run_i && tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/frame_tx_handshake.sv
module frame_tx_handshake
  import ftx_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int ACK_TICKS = 160,
  parameter int WBC_TICKS = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              send_req_i,
  input  logic [ADDR_W-1:0] frame_last_i,
  output logic              buf_rd_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_data_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_frm_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              failed_o
);

  ftx_state_e        st_q, st_d;
  logic              retry_q, retry_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;
  logic              tmr_clr, tmr_exp;
  logic              last_taken, accept, reject;
  logic              in_send, in_wait, in_gap;

  assign in_send = (st_q == ST_SEND);
  assign in_wait = (st_q == ST_WAIT);
  assign in_gap  = (st_q == ST_GAP);

  ftx_byte_feeder #(.ADDR_W(ADDR_W)) u_feeder (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (in_send),
    .last_i       (last_q),
    .tx_ready_i   (tx_ready_i),
    .addr_o       (buf_addr_o),
    .tx_valid_o   (tx_valid_o),
    .last_taken_o (last_taken)
  );

  ftx_reply_decoder u_decoder (
    .armed_i      (in_wait),
    .rx_data_i    (rx_data_i),
    .rx_valid_i   (rx_valid_i),
    .rx_frm_err_i (rx_frm_err_i),
    .accept_o     (accept),
    .reject_o     (reject)
  );

  ftx_tick_timer #(.ACK_TICKS(ACK_TICKS), .WBC_TICKS(WBC_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .run_i     (in_wait || in_gap),
    .sel_gap_i (in_gap),
    .tick_i    (tick_i),
    .expired_o (tmr_exp)
  );

  assign buf_rd_o  = tx_valid_o;
  assign tx_data_o = buf_data_i;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign failed_o  = fail_q;

  always_comb begin
    st_d    = st_q;
    retry_d = retry_q;
    last_d  = last_q;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    tmr_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (send_req_i) begin
          st_d    = ST_SEND;
          retry_d = 1'b0;
          last_d  = frame_last_i;
        end
      end
      ST_SEND: begin
        if (last_taken) begin
          st_d    = ST_WAIT;
          tmr_clr = 1'b1;
        end
      end
      ST_WAIT: begin
        if (accept) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else if (reject) begin
          if (retry_q) begin
            st_d   = ST_IDLE;
            fail_d = 1'b1;
          end else begin
            st_d    = ST_GAP;
            retry_d = 1'b1;
            tmr_clr = 1'b1;
          end
        end else if (tmr_exp) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_exp) st_d = ST_SEND;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      retry_q <= 1'b0;
      last_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      retry_q <= retry_d;
      last_q  <= last_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

endmodule

// File: rtl/ftx_checker.sv
module ftx_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              failed_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic              buf_rd_o,
  input logic [ADDR_W-1:0] buf_addr_o,
  input logic              retry_q
);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(buf_addr_o)));

  assert_no_tx_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tx_valid_o);

  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && failed_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_ends_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || failed_o) |-> ($past(busy_o) && !busy_o));

  assert_fail_after_retry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failed_o |-> $past(retry_q));

  assert_read_with_offer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_o |-> busy_o);

endmodule

bind frame_tx_handshake ftx_checker #(.ADDR_W(ADDR_W)) u_ftx_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .failed_o   (failed_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .buf_rd_o   (buf_rd_o),
  .buf_addr_o (buf_addr_o),
  .retry_q    (retry_q)
);

// File: tb/frame_tx_handshake_bench.sv
module frame_tx_handshake_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int ACK_T      = 160;
  localparam int WBC_T      = 20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tick, send_req;
  logic [ADDR_W-1:0] frame_last;
  logic              buf_rd;
  logic [ADDR_W-1:0] buf_addr;
  logic [7:0]        buf_data;
  logic [7:0]        tx_data;
  logic              tx_valid, tx_ready;
  logic [7:0]        rx_data;
  logic              rx_valid, rx_err;
  logic              busy, done, failed;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pattern(input logic [ADDR_W-1:0] a);
    return (8'(a) * 8'h11) ^ 8'h5A;
  endfunction

  assign buf_data = pattern(buf_addr);

  frame_tx_handshake #(.ADDR_W(ADDR_W), .ACK_TICKS(ACK_T), .WBC_TICKS(WBC_T)) u_frame_tx_handshake (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .send_req_i(send_req),
    .frame_last_i(frame_last), .buf_rd_o(buf_rd), .buf_addr_o(buf_addr),
    .buf_data_i(buf_data), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_frm_err_i(rx_err), .busy_o(busy), .done_o(done), .failed_o(failed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic give_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1; cyc(); tick = 1'b0; cyc();
    end
  endtask

  task automatic rx_byte(input logic [7:0] b, input logic err);
    rx_data = b; rx_valid = 1'b1; rx_err = err; cyc();
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  // Sends bytes 0..last with one stall per byte; optional request first.
  task automatic pump_frame(input logic [ADDR_W-1:0] last, input bit request);
    if (request) begin
      frame_last = last; send_req = 1'b1; cyc(); send_req = 1'b0;
      chk("R1 busy after request", busy, 1);
    end
    for (int i = 0; i <= int'(last); i++) begin
      chk("R2 offer valid", tx_valid, 1);
      chk("R2 index order", buf_addr, i);
      chk("R2 byte value", tx_data, pattern(ADDR_W'(i)));
      cyc();
      chk("R2 hold while stalled", {tx_valid, buf_addr}, {1'b1, ADDR_W'(i)});
      tx_ready = 1'b1; cyc(); tx_ready = 1'b0;
    end
    chk("R2 no offer after last byte", tx_valid, 0);
  endtask

  task automatic t_reset();
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 failed", failed, 0);
    chk("R10 tx_valid", tx_valid, 0);
    chk("R10 buf_rd", buf_rd, 0);
  endtask

  task automatic t_ack();
    pump_frame(3, 1'b1);
    rx_byte(8'h41, 1'b0);
    chk("R8 other byte ignored done", done, 0);
    chk("R8 other byte ignored busy", busy, 1);
    rx_byte(8'h06, 1'b0);
    chk("R3 done on ack", done, 1);
    chk("R3 no failed", failed, 0);
    chk("R1 busy low at result", busy, 0);
    cyc();
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic t_timeout();
    pump_frame(0, 1'b1);
    give_ticks(ACK_T - 1);
    chk("R4 no early done", done, 0);
    chk("R4 still busy", busy, 1);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R4 done at window end", done, 1);
    cyc();
  endtask

  task automatic t_frame_err();
    pump_frame(2, 1'b1);
    frame_last = 5; send_req = 1'b1; cyc(); send_req = 1'b0;
    rx_byte(8'h15, 1'b1);
    chk("R5 framing error counts as ack", done, 1);
    chk("R5 no failed", failed, 0);
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk("R1 busy request ignored", {busy, tx_valid}, 2'b00);
    end
  endtask

  task automatic t_nak_retry();
    pump_frame(2, 1'b1);
    rx_byte(8'h15, 1'b0);
    chk("R6 no result on first nak", {done, failed}, 2'b00);
    give_ticks(WBC_T - 1);
    chk("R6 silent during gap", tx_valid, 0);
    chk("R6 busy during gap", busy, 1);
    tick = 1'b1; cyc(); tick = 1'b0;
    pump_frame(2, 1'b0);
    rx_byte(8'h06, 1'b0);
    chk("R6 ack after retry", {done, failed}, 2'b10);
    cyc();
  endtask

  task automatic t_fail();
    pump_frame(1, 1'b1);
    rx_byte(8'h15, 1'b0);
    give_ticks(WBC_T);
    pump_frame(1, 1'b0);
    rx_byte(8'h15, 1'b0);
    chk("R7 failed on second nak", failed, 1);
    chk("R7 no done", done, 0);
    chk("R7 idle", busy, 0);
    cyc();
    chk("R9 failed one cycle", failed, 0);
    give_ticks(WBC_T + 2);
    chk("R7 no third send", {busy, tx_valid}, 2'b00);
  endtask

  task automatic t_idle_rx();
    rx_byte(8'h06, 1'b0);
    chk("R8 idle ack ignored", {busy, done}, 2'b00);
    rx_byte(8'h15, 1'b1);
    chk("R8 idle error ignored", {busy, done, failed}, 3'b000);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; send_req = 1'b0; frame_last = '0;
    tx_ready = 1'b0; rx_data = '0; rx_valid = 1'b0; rx_err = 1'b0;
    repeat (3) cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_ack();
    t_timeout();
    t_frame_err();
    t_nak_retry();
    t_fail();
    t_idle_rx();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule